// File: doc/BRIEF.md
# Hash engine control register file

This block is the software-facing control plane of a hash accelerator. A host writes a 32-bit word-addressed bus to set the source address, destination address, key buffer address and source length of a job. Each register keeps only the bits its mask allows. A write to the hash command register masks the value, decodes a two-level algorithm selection and starts the datapath with a single-cycle start pulse. It does this only when the selection is a legal one and no job is in progress.

The hash datapath is outside the block. It sees a start pulse, the decoded algorithm and two mode flags, and it answers with a done pulse. On done the block sets a completion bit in the status register, whether or not interrupts are enabled. It raises the interrupt line only when the command that started the job had its interrupt-enable bit set. Writing one to the completion bit clears both the bit and the interrupt.

Top module: `hash_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `opStart` is low.
- R2: Register word addresses and write masks are:
  - crypt command at word 4 (byte 0x10), stored whole and starting nothing;
  - status at word 7 (0x1C);
  - source at word 8 (0x20), mask 0x7FFFFFFF;
  - destination at word 9 (0x24), mask 0x7FFFFFF8;
  - key buffer at word 10 (0x28), mask 0x7FFFFFF8;
  - length at word 11 (0x2C), mask 0x0FFFFFFF;
  - hash command at word 12 (0x30), mask 0x00147FFF.
  A read returns the stored value combinationally in the same cycle.
- R3: Every other word address, including those above word 12, reads zero, and a write to it changes no register.
- R4: A command write whose masked value holds a legal selection raises `opStart` for exactly one cycle, starting the cycle after the write. With the same timing, `opAlgo` takes the code of the selected algorithm. The main select is bits 6:4 and the sub-select is bits 12:10. The legal pairs, written main/sub with their `opAlgo` code, are:
  - 000/000 gives MD5, code 0;
  - 010/000 gives SHA-1, code 1;
  - 100/000 gives SHA-224, code 2;
  - 101/000 gives SHA-256, code 3;
  - 110/000 gives SHA-512, code 4;
  - 110/001 gives SHA-384, code 5;
  - 110/010 gives SHA-512/256, code 6.
- R5: Any other main/sub pair is invalid. It produces no start pulse, but the masked command value is still stored and read back.
- R6: With each start, `opAccum` is latched as 1 when command bits 8:7 equal 10, and `opScatter` is latched as command bit 18.
- R7: A command written after a start and before the matching `opDone` is stored but issues no start. `opAlgo` keeps its value.
- R8: `opDone` sets status bit 9 from the next cycle on, whatever the interrupt enable.
- R9: `irq` rises together with status bit 9 only if bit 9 of the started command was set. Otherwise it stays low.
- R10: A status write with bit 9 set clears status bit 9 and `irq` from the next cycle. A status write with bit 9 clear changes nothing. When `opDone` arrives in the same cycle as a clearing write, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the current address |
| busAddr | input | ADDR_W (10) | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| opDone | input | 1 | Datapath completion pulse |
| opStart | output | 1 | One-cycle start pulse to the datapath |
| opAlgo | output | 3 | Algorithm code latched at start |
| opAccum | output | 1 | Accumulative digest mode latched at start |
| opScatter | output | 1 | Scatter-gather enable latched at start |
| irq | output | 1 | Completion interrupt |

## Verification
The command decode is tried with every legal main/sub pair. This tells apart the seven algorithm codes and the sub-select that only the 110 family honours. It is also tried with an illegal sub-select under SHA-512, with the unused main codes 011 and 111, and with a nonzero sub-select under SHA-1. These show that the sub field must be zero outside the family.

Further command values carry the interrupt enable, set bits outside the command mask, and the accumulative and scatter-gather fields. They separate masking done before the decode from masking done after it, and an interrupt that follows the enable from one that does not. Directed cases cover:
- a command written while busy;
- a status write without bit 9;
- a clearing write that coincides with done;
- writes to unmapped addresses;
- a reset taken while the interrupt is high.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

  localparam int DATA_W       = 32;
  localparam int NUM_SEL      = 8;
  localparam int DONE_BIT     = 9;

  localparam int WIDX_CRYPT   = 4;
  localparam int WIDX_STATUS  = 7;
  localparam int WIDX_SRC     = 8;
  localparam int WIDX_DST     = 9;
  localparam int WIDX_KEY     = 10;
  localparam int WIDX_LEN     = 11;
  localparam int WIDX_CMD     = 12;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_CRYPT  = 3'd1,
    SEL_STATUS = 3'd2,
    SEL_SRC    = 3'd3,
    SEL_DST    = 3'd4,
    SEL_KEY    = 3'd5,
    SEL_LEN    = 3'd6,
    SEL_CMD    = 3'd7
  } regSel_e;

  typedef struct packed {
    regSel_e sel;
    logic    wr;
  } regAccess_t;

  typedef enum logic [2:0] {
    ALG_MD5      = 3'd0,
    ALG_SHA1     = 3'd1,
    ALG_SHA224   = 3'd2,
    ALG_SHA256   = 3'd3,
    ALG_SHA512   = 3'd4,
    ALG_SHA384   = 3'd5,
    ALG_SHA512T  = 3'd6,
    ALG_BAD      = 3'd7
  } hashAlgo_e;

  function automatic hashAlgo_e decodeAlgo(input logic [2:0] mainSel,
                                           input logic [2:0] subSel);
    hashAlgo_e res;
    res = ALG_BAD;
    case (mainSel)
      3'b000: if (subSel == 3'b000) res = ALG_MD5;
      3'b010: if (subSel == 3'b000) res = ALG_SHA1;
      3'b100: if (subSel == 3'b000) res = ALG_SHA224;
      3'b101: if (subSel == 3'b000) res = ALG_SHA256;
      3'b110: begin
        case (subSel)
          3'b000:  res = ALG_SHA512;
          3'b001:  res = ALG_SHA384;
          3'b010:  res = ALG_SHA512T;
          default: res = ALG_BAD;
        endcase
      end
      default: res = ALG_BAD;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
  import hcr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        wrMainSel,
  input  logic [2:0]        wrSubSel,
  input  logic [1:0]        wrDigest,
  input  logic              wrIrqEn,
  input  logic              wrScatter,
  input  logic              wrClrDone,
  input  logic              opDone,
  output regAccess_t        acc,
  output logic              opStart,
  output hashAlgo_e         opAlgo,
  output logic              opAccum,
  output logic              opScatter,
  output logic              statusDone,
  output logic              irq
);

  regSel_e   selNow;
  hashAlgo_e algoDec;
  logic      cmdWr;
  logic      clrReq;
  logic      launch;
  logic      busy;
  logic      irqEnHeld;

  // word address decode shared by the read and write paths
  always_comb begin
    selNow = SEL_NONE;
    if (busAddr == ADDR_W'(WIDX_CRYPT))       selNow = SEL_CRYPT;
    else if (busAddr == ADDR_W'(WIDX_STATUS)) selNow = SEL_STATUS;
    else if (busAddr == ADDR_W'(WIDX_SRC))    selNow = SEL_SRC;
    else if (busAddr == ADDR_W'(WIDX_DST))    selNow = SEL_DST;
    else if (busAddr == ADDR_W'(WIDX_KEY))    selNow = SEL_KEY;
    else if (busAddr == ADDR_W'(WIDX_LEN))    selNow = SEL_LEN;
    else if (busAddr == ADDR_W'(WIDX_CMD))    selNow = SEL_CMD;
  end

  assign acc.sel = selNow;
  assign acc.wr  = busWrEn;

  assign algoDec = decodeAlgo(wrMainSel, wrSubSel);
  assign cmdWr   = busWrEn && (selNow == SEL_CMD);
  assign clrReq  = busWrEn && (selNow == SEL_STATUS) && wrClrDone;
  assign launch  = cmdWr && (algoDec != ALG_BAD) && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opStart   <= 1'b0;
      opAlgo    <= ALG_MD5;
      opAccum   <= 1'b0;
      opScatter <= 1'b0;
      irqEnHeld <= 1'b0;
      busy      <= 1'b0;
    end else begin
      opStart <= launch;
      if (launch) begin
        opAlgo    <= algoDec;
        opAccum   <= (wrDigest == 2'b10);
        opScatter <= wrScatter;
        irqEnHeld <= wrIrqEn;
        busy      <= 1'b1;
      end else if (opDone) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusDone <= 1'b0;
      irq        <= 1'b0;
    end else if (opDone) begin
      statusDone <= 1'b1;
      irq        <= irq | irqEnHeld;
    end else if (clrReq) begin
      statusDone <= 1'b0;
      irq        <= 1'b0;
    end
  end

  // R4: start never lasts two cycles
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> !opStart);

  // R5: an illegal selection is never followed by a start
  assert_bad_algo_no_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && algoDec == ALG_BAD) |=> !opStart);

  // R7: no start while a job is outstanding
  assert_busy_no_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busy) |=> !opStart);

  // R8: done always leaves the completion bit set
  assert_done_sets_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> statusDone);

  // R9: the interrupt never stands without the completion bit
  assert_irq_implies_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statusDone);

  // R10: a clearing write without done empties both
  assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !opDone) |=> (!statusDone && !irq));

endmodule

// File: rtl/hcr_regs.sv
module hcr_regs
  import hcr_pkg::*;
#(
  parameter logic [DATA_W-1:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [DATA_W-1:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [DATA_W-1:0] KEY_MASK = 32'h7FFF_FFF8,
  parameter logic [DATA_W-1:0] LEN_MASK = 32'h0FFF_FFFF,
  parameter logic [DATA_W-1:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  regAccess_t        acc,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusDone,
  output logic [DATA_W-1:0] rdData
);

  // slot masks in regSel_e order; a zero mask means no storage
  localparam logic [DATA_W-1:0] MASK_TAB [NUM_SEL] = '{
    '0, '1, '0, SRC_MASK, DST_MASK, KEY_MASK, LEN_MASK, CMD_MASK
  };

  logic [DATA_W-1:0] slotVal [NUM_SEL];
  logic [DATA_W-1:0] statusWord;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_slot
    if (MASK_TAB[i] != '0) begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= '0;
        end else if (acc.wr && acc.sel == regSel_e'(3'(i))) begin
          q <= wrData & MASK_TAB[i];
        end
      end
      assign slotVal[i] = q;
    end else begin : g_empty
      assign slotVal[i] = '0;
    end
  end

  assign statusWord = DATA_W'(statusDone) << DONE_BIT;

  always_comb begin
    if (acc.sel == SEL_STATUS) rdData = statusWord;
    else                       rdData = slotVal[acc.sel];
  end

  // R2: the length register never shows bits outside its mask
  assert_len_masked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (acc.sel == SEL_LEN) |-> ((rdData & ~LEN_MASK) == '0));

  // R2: a read of status carries only the completion bit
  assert_status_only_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (acc.sel == SEL_STATUS) |-> ((rdData & ~(DATA_W'(1) << DONE_BIT)) == '0));

endmodule

// File: rtl/hash_ctrl_regs.sv
module hash_ctrl_regs
  import hcr_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter logic [DATA_W-1:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [DATA_W-1:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [DATA_W-1:0] KEY_MASK = 32'h7FFF_FFF8,
  parameter logic [DATA_W-1:0] LEN_MASK = 32'h0FFF_FFFF,
  parameter logic [DATA_W-1:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              opDone,
  output logic              opStart,
  output logic [2:0]        opAlgo,
  output logic              opAccum,
  output logic              opScatter,
  output logic              irq
);

  regAccess_t acc;
  hashAlgo_e  algoCode;
  logic       statusDone;

  hcr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .wrMainSel  (busWrData[6:4] & CMD_MASK[6:4]),
    .wrSubSel   (busWrData[12:10] & CMD_MASK[12:10]),
    .wrDigest   (busWrData[8:7] & CMD_MASK[8:7]),
    .wrIrqEn    (busWrData[9] & CMD_MASK[9]),
    .wrScatter  (busWrData[18] & CMD_MASK[18]),
    .wrClrDone  (busWrData[DONE_BIT]),
    .opDone     (opDone),
    .acc        (acc),
    .opStart    (opStart),
    .opAlgo     (algoCode),
    .opAccum    (opAccum),
    .opScatter  (opScatter),
    .statusDone (statusDone),
    .irq        (irq)
  );

  hcr_regs #(
    .SRC_MASK (SRC_MASK),
    .DST_MASK (DST_MASK),
    .KEY_MASK (KEY_MASK),
    .LEN_MASK (LEN_MASK),
    .CMD_MASK (CMD_MASK)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .acc        (acc),
    .wrData     (busWrData),
    .statusDone (statusDone),
    .rdData     (busRdData)
  );

  assign opAlgo = algoCode;

endmodule

// File: tb/sim_hash_ctrl_regs.sv
`timescale 1ns/1ps
module sim_hash_ctrl_regs;

  typedef struct packed {
    logic [31:0] data;
    logic        ok;
    logic [2:0]  alg;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 1'b1, 3'd0},
    '{32'h0000_0020, 1'b1, 3'd1},
    '{32'h0000_0040, 1'b1, 3'd2},
    '{32'h0000_0050, 1'b1, 3'd3},
    '{32'h0000_0060, 1'b1, 3'd4},
    '{32'h0000_0460, 1'b1, 3'd5},
    '{32'h0000_0860, 1'b1, 3'd6},
    '{32'h0000_0C60, 1'b0, 3'd0},
    '{32'h0000_0030, 1'b0, 3'd0},
    '{32'h0000_0070, 1'b0, 3'd0},
    '{32'h0000_0420, 1'b0, 3'd0},
    '{32'h0000_0250, 1'b1, 3'd3},
    '{32'hFF80_0250, 1'b1, 3'd3},
    '{32'h0004_0150, 1'b1, 3'd3}
  };

  localparam logic [31:0] CMDM = 32'h0014_7FFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        opDone = 1'b0;
  logic        opStart;
  logic [2:0]  opAlgo;
  logic        opAccum;
  logic        opScatter;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hash_ctrl_regs u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .opDone(opDone),
    .opStart(opStart), .opAlgo(opAlgo), .opAccum(opAccum),
    .opScatter(opScatter), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [9:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic pulseDone();
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int w = 0; w < 16; w++) rdChk("R1 reset read", 10'(w), 32'h0);
    chk("R1 irq at reset", 32'(irq), 32'h0);
    chk("R1 start at reset", 32'(opStart), 32'h0);

    // R2 masks and crypt command
    wrReg(10'd8, 32'hFFFF_FFFF);  rdChk("R2 src mask", 10'd8, 32'h7FFF_FFFF);
    wrReg(10'd9, 32'hFFFF_FFFF);  rdChk("R2 dst mask", 10'd9, 32'h7FFF_FFF8);
    wrReg(10'd10, 32'hFFFF_FFFF); rdChk("R2 key mask", 10'd10, 32'h7FFF_FFF8);
    wrReg(10'd11, 32'hFFFF_FFFF); rdChk("R2 len mask", 10'd11, 32'h0FFF_FFFF);
    wrReg(10'd4, 32'hDEAD_BEEF);
    chk("R2 crypt no start", 32'(opStart), 32'h0);
    rdChk("R2 crypt stored", 10'd4, 32'hDEAD_BEEF);

    // R3 unmapped addresses
    wrReg(10'd0, 32'hFFFF_FFFF);
    wrReg(10'd5, 32'hFFFF_FFFF);
    wrReg(10'd16, 32'hFFFF_FFFF);
    wrReg(10'h3FF, 32'hFFFF_FFFF);
    rdChk("R3 word0", 10'd0, 32'h0);
    rdChk("R3 word5", 10'd5, 32'h0);
    rdChk("R3 word16", 10'd16, 32'h0);
    rdChk("R3 word3FF", 10'h3FF, 32'h0);
    rdChk("R3 src untouched", 10'd8, 32'h7FFF_FFFF);
    rdChk("R3 status untouched", 10'd7, 32'h0);

    // table walk over command values
    for (int v = 0; v < NV; v++) begin
      logic [31:0] m;
      m = VECS[v].data & CMDM;
      wrReg(10'd12, VECS[v].data);
      if (VECS[v].ok) begin
        chk("R4 start raised", 32'(opStart), 32'h1);
        chk("R4 algo code", 32'(opAlgo), 32'(VECS[v].alg));
        chk("R6 accum flag", 32'(opAccum), 32'(m[8:7] == 2'b10));
        chk("R6 scatter flag", 32'(opScatter), 32'(m[18]));
        rdChk("R4 cmd readback", 10'd12, m);
        @(negedge clk);
        chk("R4 start one cycle", 32'(opStart), 32'h0);
        pulseDone();
        rdChk("R8 done bit", 10'd7, 32'h0000_0200);
        chk("R9 irq follows enable", 32'(irq), 32'(m[9]));
        wrReg(10'd7, 32'h0000_0200);
        rdChk("R10 cleared bit", 10'd7, 32'h0);
        chk("R10 cleared irq", 32'(irq), 32'h0);
      end else begin
        chk("R5 no start", 32'(opStart), 32'h0);
        rdChk("R5 cmd stored", 10'd12, m);
        @(negedge clk);
        chk("R5 still no start", 32'(opStart), 32'h0);
        rdChk("R5 no completion", 10'd7, 32'h0);
      end
    end

    // R7 command while busy
    wrReg(10'd12, 32'h0000_0050);
    chk("R7 first start", 32'(opStart), 32'h1);
    @(negedge clk);
    wrReg(10'd12, 32'h0000_0020);
    chk("R7 no start when busy", 32'(opStart), 32'h0);
    chk("R7 algo held", 32'(opAlgo), 32'd3);
    rdChk("R7 cmd stored", 10'd12, 32'h0000_0020);
    pulseDone();
    wrReg(10'd12, 32'h0000_0020);
    chk("R7 start after done", 32'(opStart), 32'h1);
    chk("R7 new algo", 32'(opAlgo), 32'd1);
    @(negedge clk);
    pulseDone();
    wrReg(10'd7, 32'h0000_0200);

    // R10 write without bit 9, then coincident done and clear
    wrReg(10'd12, 32'h0000_0250);
    @(negedge clk);
    pulseDone();
    chk("R9 irq high", 32'(irq), 32'h1);
    wrReg(10'd7, 32'hFFFF_FDFF);
    rdChk("R10 no clear without bit9", 10'd7, 32'h0000_0200);
    chk("R10 irq kept", 32'(irq), 32'h1);
    busAddr = 10'd7; busWrData = 32'h0000_0200; busWrEn = 1'b1; opDone = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; opDone = 1'b0;
    rdChk("R10 done wins", 10'd7, 32'h0000_0200);

    // R1 reset while irq high
    chk("R1 irq before reset", 32'(irq), 32'h1);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rdChk("R1 status after reset", 10'd7, 32'h0);
    rdChk("R1 cmd after reset", 10'd12, 32'h0);
    rdChk("R1 src after reset", 10'd8, 32'h0);
    rdChk("R1 crypt after reset", 10'd4, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule